// File: doc/BRIEF.md
# Delayed Transmit/Receive Switch Controller

This block drives the transmit/receive antenna switch of a radio front end. The switch follows the state of the transmit FIFO. When the FIFO starts holding samples, the switch moves to transmit. When the FIFO drains, the switch moves back to receive. Each of the two moves waits for its own programmable number of clock cycles. This lets the switch line up with the latency of the transmit datapath that sits behind the FIFO.

Software programs the two wait times through a small register write port with address, data and strobe. The same port loads two output patterns, one for each mode. The block drives the pattern that matches the current mode, so the switch can steer several front-end control lines. The FIFO-empty input is taken to be synchronous to the block clock. The mode output comes straight from a flip-flop.

Top module: `tr_switch_delay`

## Requirements
- R1: In reset (active-low `rst_n` sampled low at a rising edge), `txmode_o` goes to 0 (receive), both delays go to 0, and both patterns go to 0, so `pattern_o` reads 0.
- R2: A write to address 2 sets the 16-bit transmit delay D. `fifo_empty_i` may then fall while the block is in receive mode and stay low. `txmode_o` rises to 1 right after the (D+1)-th rising edge that samples it low, counting the first such edge.
- R3: A write to address 3 sets the 16-bit receive delay D. `fifo_empty_i` may then rise while the block is in transmit mode and stay high. `txmode_o` falls to 0 right after the (D+1)-th rising edge that samples it high, counting the first such edge.
- R4: A delay of 0 switches the mode on the first rising edge that sees the new FIFO state.
- R5: The two delays are separate registers. Writing one changes neither the other register nor the timing of the other direction.
- R6: The FIFO state may return to the value that matches the current mode before a pending delay has expired. The pending count is then discarded and `txmode_o` does not change. A later FIFO change starts a fresh full count.
- R7: A delay write made while a count is running does not change that count. The new value applies from the next triggering FIFO change.
- R8: The transmit pattern register is at address PAT_BASE+3*SLOT and the receive pattern register is at PAT_BASE+3*SLOT+1 (defaults 8 and 9). `pattern_o` equals the transmit pattern while `txmode_o` is 1 and the receive pattern while it is 0.
- R9: Writes to any other address, and any cycle with `cfg_we_i` low, leave all four registers unchanged. This includes the pattern addresses of other slots, such as 11.
- R10: `txmode_o` changes only on a rising edge of `clk`, and only when the sampled FIFO state disagrees with the current mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_empty_i | input | 1 | Transmit FIFO empty flag, synchronous to clk |
| cfg_addr_i | input | 7 | Register write address |
| cfg_data_i | input | 16 | Register write data |
| cfg_we_i | input | 1 | Register write strobe |
| txmode_o | output | 1 | 1 = transmit mode, 0 = receive mode |
| pattern_o | output | 16 | Output pattern for the current mode |

## Verification
The bench measures the exact edge count from a FIFO change to the switch move, for zero, short and unequal delays in both directions. An off-by-one counter would shift every one of these counts by a cycle. It makes a FIFO pulse shorter than the pending delay, in both directions. A design that kept the stale count would flip the switch late, and one that carried the partial count into the next event would switch too early. It also rewrites a delay in the middle of a count and checks that the running count keeps its old length while the next event uses the new one. Finally, it writes to a neighbouring slot's pattern address. A decoder that ignored the slot offset would corrupt the visible pattern.

// File: rtl/tr_sw_pkg.sv
// Package: shared mode type and fixed register addresses for the
// delayed transmit/receive switch. Assumes a 7-bit register address space.
package tr_sw_pkg;

    typedef enum logic {
        MODE_RX = 1'b0,
        MODE_TX = 1'b1
    } sw_mode_e;

    // Delay register addresses; the transmit delay sits one below the receive.
    localparam int unsigned DLY_ADDR_BASE = 2;
    localparam int unsigned NUM_MODES     = 2;

endpackage

// File: rtl/tr_cfg_regs.sv
// Configuration register file: two delay registers and two pattern
// registers (one of each per mode), written through a simple strobe port.
// Assumes single-cycle writes; a write is visible after the writing edge.
module tr_cfg_regs
    import tr_sw_pkg::*;
#(
    parameter int unsigned ADDR_W   = 7,
    parameter int unsigned DLY_W    = 16,
    parameter int unsigned PAT_W    = 16,
    parameter int unsigned PAT_BASE = 8,
    parameter int unsigned SLOT     = 0
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [ADDR_W-1:0]                addr_i,
    input  logic [DLY_W-1:0]                 data_i,
    input  logic                             we_i,
    output logic [NUM_MODES-1:0][DLY_W-1:0]  dly_o,
    output logic [NUM_MODES-1:0][PAT_W-1:0]  pat_o
);

    localparam int unsigned PAT_SLOT_BASE = PAT_BASE + 3 * SLOT;

    // Index 0 = receive mode, index 1 = transmit mode, for both register kinds.
    for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
        // Transmit delay at DLY_ADDR_BASE, receive delay at DLY_ADDR_BASE+1.
        localparam logic [ADDR_W-1:0] DLY_ADDR =
            ADDR_W'(DLY_ADDR_BASE + (NUM_MODES - 1 - m));
        // Transmit pattern at slot base, receive pattern at slot base + 1.
        localparam logic [ADDR_W-1:0] PAT_ADDR =
            ADDR_W'(PAT_SLOT_BASE + (NUM_MODES - 1 - m));

        logic [DLY_W-1:0] dly_q;
        logic [PAT_W-1:0] pat_q;

        // Delay register for this mode: reset to zero, load on matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dly_q <= '0;
            end else if (we_i && addr_i == DLY_ADDR) begin
                dly_q <= data_i;
            end
        end

        // Pattern register for this mode: reset to zero, load on matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pat_q <= '0;
            end else if (we_i && addr_i == PAT_ADDR) begin
                pat_q <= PAT_W'(data_i);
            end
        end

        assign dly_o[m] = dly_q;
        assign pat_o[m] = pat_q;

        // R5
        dly_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (we_i && addr_i == DLY_ADDR) |=> (dly_o[m] == $past(data_i)));

        // R9
        dly_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(we_i && addr_i == DLY_ADDR) |=> $stable(dly_o[m]));

        // R9
        pat_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(we_i && addr_i == PAT_ADDR) |=> $stable(pat_o[m]));
    end

endmodule

// File: rtl/tr_edge_timer.sv
// Edge timer: holds the switch mode and delays each mode change by the
// delay of the target mode. The delay is latched when a change starts, so
// later register writes do not affect it. If the wanted mode goes back to
// the current mode, the pending change is dropped.
// Assumes want_i is synchronous to clk.
module tr_edge_timer
    import tr_sw_pkg::*;
#(
    parameter int unsigned DLY_W = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  sw_mode_e                         want_i,
    input  logic [NUM_MODES-1:0][DLY_W-1:0]  dly_i,
    output sw_mode_e                         mode_o
);

    sw_mode_e         mode_q;
    logic             busy_q;
    logic [DLY_W-1:0] cnt_q;
    logic [DLY_W-1:0] start_dly;

    // Delay of the mode being moved to.
    always_comb start_dly = dly_i[want_i];

    // Mode state machine with cancellable down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RX;
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (want_i == mode_q) begin
            busy_q <= 1'b0;
        end else if (!busy_q) begin
            if (start_dly == '0) begin
                mode_q <= want_i;
            end else begin
                cnt_q  <= start_dly;
                busy_q <= 1'b1;
            end
        end else if (cnt_q <= DLY_W'(1)) begin
            mode_q <= want_i;
            busy_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q - DLY_W'(1);
        end
    end

    assign mode_o = mode_q;

    // R6
    hold_when_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (want_i == mode_o) |=> (mode_o == $past(mode_o)));

    // R4
    zero_dly_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (want_i != mode_o && !busy_q && start_dly == '0) |=> (mode_o == $past(want_i)));

    // R2
    no_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q > DLY_W'(1)) |=> (mode_o == $past(mode_o)));

    // R7
    cnt_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && want_i != mode_o && cnt_q > DLY_W'(1)) |=> (busy_q && cnt_q == $past(cnt_q) - DLY_W'(1)));

endmodule

// File: rtl/tr_switch_delay.sv
// Top of the delayed transmit/receive switch. The transmit FIFO state picks
// the wanted mode (non-empty = transmit). The edge timer delays each change
// by its programmed delay, and the pattern of the current mode is driven out.
// Assumes fifo_empty_i is synchronous to clk; reset is synchronous, active low.
module tr_switch_delay
    import tr_sw_pkg::*;
#(
    parameter int unsigned ADDR_W   = 7,
    parameter int unsigned DLY_W    = 16,
    parameter int unsigned PAT_W    = 16,
    parameter int unsigned PAT_BASE = 8,
    parameter int unsigned SLOT     = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_empty_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [DLY_W-1:0]  cfg_data_i,
    input  logic              cfg_we_i,
    output logic              txmode_o,
    output logic [PAT_W-1:0]  pattern_o
);

    logic [NUM_MODES-1:0][DLY_W-1:0] dly;
    logic [NUM_MODES-1:0][PAT_W-1:0] pat;
    sw_mode_e                        want;
    sw_mode_e                        mode;

    // Wanted mode follows the FIFO: any queued data asks for transmit.
    always_comb want = fifo_empty_i ? MODE_RX : MODE_TX;

    tr_cfg_regs #(
        .ADDR_W   (ADDR_W),
        .DLY_W    (DLY_W),
        .PAT_W    (PAT_W),
        .PAT_BASE (PAT_BASE),
        .SLOT     (SLOT)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr_i (cfg_addr_i),
        .data_i (cfg_data_i),
        .we_i   (cfg_we_i),
        .dly_o  (dly),
        .pat_o  (pat)
    );

    tr_edge_timer #(
        .DLY_W (DLY_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .want_i (want),
        .dly_i  (dly),
        .mode_o (mode)
    );

    // Drive the mode flag and the pattern of the current mode.
    always_comb begin
        txmode_o  = (mode == MODE_TX);
        pattern_o = pat[mode];
    end

    // R1
    reset_rx_chk: assert property (@(posedge clk)
        !rst_n |=> !txmode_o);

    // R10
    move_needs_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txmode_o != fifo_empty_i) |=> $stable(txmode_o));

endmodule

// File: tb/tr_switch_delay_bench.sv
module tr_switch_delay_bench;

    localparam int PAT_TX_ADDR = 8;
    localparam int PAT_RX_ADDR = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_empty = 1'b1;
    logic [6:0]  addr = '0;
    logic [15:0] data = '0;
    logic        we = 1'b0;
    logic        txmode;
    logic [15:0] pattern;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    tr_switch_delay u_tr_switch_delay (
        .clk          (clk),
        .rst_n        (rst_n),
        .fifo_empty_i (fifo_empty),
        .cfg_addr_i   (addr),
        .cfg_data_i   (data),
        .cfg_we_i     (we),
        .txmode_o     (txmode),
        .pattern_o    (pattern)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        addr = 7'(a); data = 16'(d); we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    // Count rising edges until txmode reaches target (-1 on timeout).
    task automatic wait_mode(input logic target, output int n);
        n = 0;
        for (int i = 0; i < 200; i++) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (txmode == target) return;
        end
        n = -1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 txmode", int'(txmode), 0);
        check("R1 pattern", int'(pattern), 0);
    endtask

    task automatic t_zero();
        int n;
        fifo_empty = 1'b0;
        wait_mode(1'b1, n); check("R4 tx zero delay", n, 1);
        fifo_empty = 1'b1;
        wait_mode(1'b0, n); check("R4 rx zero delay", n, 1);
    endtask

    task automatic t_asym();
        int n;
        wr(2, 5); wr(3, 3);
        fifo_empty = 1'b0;
        wait_mode(1'b1, n); check("R2 tx delay 5", n, 6);
        fifo_empty = 1'b1;
        wait_mode(1'b0, n); check("R3 rx delay 3", n, 4);
        wr(3, 7);
        fifo_empty = 1'b0;
        wait_mode(1'b1, n); check("R5 tx unaffected by rx write", n, 6);
        fifo_empty = 1'b1;
        wait_mode(1'b0, n); check("R3 rx delay 7", n, 8);
    endtask

    task automatic t_cancel();
        int n;
        wr(2, 10); wr(3, 10);
        fifo_empty = 1'b0;
        repeat (4) @(negedge clk);
        fifo_empty = 1'b1;
        repeat (20) @(negedge clk);
        check("R6 tx pulse cancelled", int'(txmode), 0);
        fifo_empty = 1'b0;
        wait_mode(1'b1, n); check("R6 fresh full tx count", n, 11);
        fifo_empty = 1'b1;
        repeat (4) @(negedge clk);
        fifo_empty = 1'b0;
        repeat (20) @(negedge clk);
        check("R6 rx pulse cancelled", int'(txmode), 1);
        fifo_empty = 1'b1;
        wait_mode(1'b0, n); check("R6 fresh full rx count", n, 11);
    endtask

    task automatic t_midwrite();
        int n;
        wr(2, 8); wr(3, 0);
        @(negedge clk);
        fifo_empty = 1'b0;
        @(posedge clk);
        @(negedge clk);
        addr = 7'd2; data = 16'd2; we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
        n = 2;
        if (txmode) n = -2;
        for (int i = 0; i < 50 && !txmode; i++) begin
            @(posedge clk); n++;
            @(negedge clk);
        end
        check("R7 running count keeps old delay", n, 9);
        fifo_empty = 1'b1;
        wait_mode(1'b0, n);
        fifo_empty = 1'b0;
        wait_mode(1'b1, n); check("R7 next event uses new delay", n, 3);
        fifo_empty = 1'b1;
        wait_mode(1'b0, n);
    endtask

    task automatic t_pattern();
        int n;
        wr(2, 0); wr(3, 0);
        wr(PAT_TX_ADDR, 16'hA5C3); wr(PAT_RX_ADDR, 16'h1234);
        @(negedge clk);
        check("R8 rx pattern", int'(pattern), 16'h1234);
        fifo_empty = 1'b0;
        wait_mode(1'b1, n);
        check("R8 tx pattern", int'(pattern), 16'hA5C3);
        wr(11, 16'hFFFF); wr(7, 16'hFFFF); wr(10, 16'hFFFF);
        @(negedge clk);
        check("R9 other slot write ignored", int'(pattern), 16'hA5C3);
        addr = 7'(PAT_TX_ADDR); data = 16'h0F0F; we = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 strobe low ignored", int'(pattern), 16'hA5C3);
        fifo_empty = 1'b1;
        wait_mode(1'b0, n);
        check("R9 rx delay unchanged", n, 1);
        check("R8 back to rx pattern", int'(pattern), 16'h1234);
    endtask

    task automatic t_reset_again();
        wr(2, 4);
        fifo_empty = 1'b0;
        repeat (8) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset to rx", int'(txmode), 0);
        check("R1 pattern cleared", int'(pattern), 0);
        rst_n = 1'b1;
        fifo_empty = 1'b1;
        @(negedge clk);
        check("R10 stays rx with fifo empty", int'(txmode), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_zero();
        t_asym();
        t_cancel();
        t_midwrite();
        t_pattern();
        t_reset_again();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule